// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block plays the device end of a serial keyboard link. Command bytes sent by the host arrive on one stream, and key events arrive on a second stream with a keycode that has already been translated. Bytes going back to the host, both command replies and key scan bytes, are placed in a 16-entry circular byte queue. The host receive path drains that queue one byte per handshake.

Two commands return fixed multi-byte replies. One command makes the block discard the next command byte, which carries LED settings. Each of the two lock keys has a small state machine. For every two press/release cycles of a lock key, it passes only the first press and the second release.

All three streams use valid/ready. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` falls while a multi-byte reply is being written, for one cycle per byte after the first. A key event is accepted when `key_valid` and `key_ready` are both high. `key_ready` is low whenever a command is offered or a reply is being written, so commands win over keys. A byte leaves the queue when `rx_valid` and `rx_ready` are both high. `rx_valid` is high exactly when the queue holds at least one byte. The sender must hold `cmd_data` and the key fields stable while its valid is high and ready is low.

Top module: `kbd_link_responder`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_data` is 0x00, `cmd_ready` and `key_ready` are 1, LED mode is off and both lock states are 0.
- R2: An accepted command 0x01, outside LED mode, empties the queue and then queues 0xFF, 0x04, 0x7F in that order. The first byte is visible on the cycle after acceptance.
- R3: An accepted command 0x07 or 0x0F, outside LED mode, empties the queue and then queues 0xFE, 0x21.
- R4: An accepted command 0x0E, outside LED mode, enters LED mode. The next accepted command byte has no effect on the queue and leaves LED mode.
- R5: Any other command byte accepted outside LED mode leaves the queue unchanged.
- R6: An accepted key event with `key_lock` = 0 queues `{key_release, key_code}`. Bit 7 is 1 for a release and 0 for a press.
- R7: `key_lock` = 1 or 2 selects one of two lock keys, each with a 2-bit state. A press flips bit 0 and is dropped if the state becomes 2. A release flips bit 1 and is dropped if the state becomes 3. An event that is not dropped queues as in R6.
- R8: The queue holds 16 bytes. A byte offered while it is full is discarded, even if a read happens in the same cycle, and the stored bytes are kept.
- R9: While the queue is empty, `rx_valid` is 0 and `rx_data` is 0x00. Asserting `rx_ready` then has no effect.
- R10: `cmd_ready` is 0 for the two cycles after a 0x01 is accepted and for the one cycle after a 0x07 or 0x0F is accepted. `key_ready` is 0 whenever `cmd_valid` or a reply write is active.
- R11: After a read that leaves bytes behind, `rx_valid` stays 1 on the next cycle with the next byte on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host command byte offered |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_data | input | 8 | Host command byte |
| key_valid | input | 1 | Key event offered |
| key_ready | output | 1 | Key event can be taken |
| key_code | input | 7 | Translated keycode |
| key_release | input | 1 | 1 = release, 0 = press |
| key_lock | input | 2 | 0 = ordinary key, 1 or 2 = lock key selector |
| rx_valid | output | 1 | Queue holds a byte for the host |
| rx_ready | input | 1 | Host takes the head byte |
| rx_data | output | 8 | Head byte, 0x00 when empty |

## Verification
The hardest state to reach is a full queue that a command and its reply then overwrite. The other hard cases are an LED-mode skip of a byte that would otherwise have cleared the queue, and lock keys whose two state machines are driven in an interleaved order. Directed sequences first fill the queue past its depth, place 0x0E ahead of 0x01, and walk both lock keys through a full press/release cycle twice. A seeded random mix of commands, key events, single reads and burst reads then reaches these states again in combinations the directed cases do not. A bench reference model of the queue and the lock states predicts every byte.

// File: rtl/kbd_link_pkg.sv
package kbd_link_pkg;
  localparam int KEY_W = 7;

  localparam logic [7:0] CMD_IDENT   = 8'h01;
  localparam logic [7:0] CMD_LED     = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT0 = 8'h07;
  localparam logic [7:0] CMD_LAYOUT1 = 8'h0F;

  typedef enum logic [1:0] {
    REPLY_NONE   = 2'd0,
    REPLY_IDENT  = 2'd1,
    REPLY_LAYOUT = 2'd2
  } reply_e;

  // Index of the final byte of each reply.
  function automatic logic [1:0] reply_last(input reply_e kind);
    case (kind)
      REPLY_IDENT:  return 2'd2;
      REPLY_LAYOUT: return 2'd1;
      default:      return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] reply_byte(input reply_e kind, input logic [1:0] idx);
    logic [7:0] b;
    b = 8'h00;
    if (kind == REPLY_IDENT) begin
      case (idx)
        2'd0:    b = 8'hFF;
        2'd1:    b = 8'h04;
        default: b = 8'h7F;
      endcase
    end else if (kind == REPLY_LAYOUT) begin
      b = (idx == 2'd0) ? 8'hFE : 8'h21;
    end
    return b;
  endfunction
endpackage

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             pop,
  output logic [7:0]       head_data,
  output logic [CNT_W-1:0] level
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rptr, wptr;
  logic             full, do_push, do_pop;
  logic [PTR_W-1:0] waddr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (level == CNT_W'(DEPTH));
  assign do_push = push && (clr || !full);
  assign do_pop  = pop && !clr && (level != '0);
  assign waddr   = clr ? '0 : wptr;
  assign head_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[waddr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      level <= '0;
    end else if (clr) begin
      rptr  <= '0;
      wptr  <= push ? PTR_W'(1) : '0;
      level <= push ? CNT_W'(1) : '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      level <= level + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
  import kbd_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  output logic       cmd_ready,
  output logic       q_clr,
  output logic       q_push,
  output logic [7:0] q_data,
  output logic       led_mode
);
  reply_e     kind;
  logic [1:0] idx;
  logic       busy, acc;

  assign busy      = (kind != REPLY_NONE);
  assign cmd_ready = !busy;
  assign acc       = cmd_valid && !busy;

  always_comb begin
    q_clr  = 1'b0;
    q_push = 1'b0;
    q_data = 8'h00;
    if (busy) begin
      q_push = 1'b1;
      q_data = reply_byte(kind, idx);
    end else if (acc && !led_mode) begin
      if (cmd_data == CMD_IDENT) begin
        q_clr  = 1'b1;
        q_push = 1'b1;
        q_data = reply_byte(REPLY_IDENT, 2'd0);
      end else if (cmd_data == CMD_LAYOUT0 || cmd_data == CMD_LAYOUT1) begin
        q_clr  = 1'b1;
        q_push = 1'b1;
        q_data = reply_byte(REPLY_LAYOUT, 2'd0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind     <= REPLY_NONE;
      idx      <= 2'd0;
      led_mode <= 1'b0;
    end else if (busy) begin
      if (idx == reply_last(kind)) kind <= REPLY_NONE;
      else                         idx  <= idx + 2'd1;
    end else if (acc) begin
      if (led_mode) begin
        led_mode <= 1'b0;
      end else if (cmd_data == CMD_IDENT) begin
        kind <= REPLY_IDENT;
        idx  <= 2'd1;
      end else if (cmd_data == CMD_LAYOUT0 || cmd_data == CMD_LAYOUT1) begin
        kind <= REPLY_LAYOUT;
        idx  <= 2'd1;
      end else if (cmd_data == CMD_LED) begin
        led_mode <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter #(
  parameter int NUM_LOCKS = 2,
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_fire,
  input  logic [ID_W-1:0] ev_lock,
  input  logic            ev_release,
  output logic            ev_drop
);
  logic [NUM_LOCKS-1:0] drop_vec;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    logic [1:0] st, nxt;
    logic       hit;
    assign hit = ev_fire && (ev_lock == ID_W'(g + 1));
    assign nxt = ev_release ? (st ^ 2'b10) : (st ^ 2'b01);
    assign drop_vec[g] = hit && (nxt == (ev_release ? 2'd3 : 2'd2));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st <= 2'd0;
      else if (hit) st <= nxt;
    end
  end

  assign ev_drop = |drop_vec;
endmodule

// File: rtl/kbd_link_responder.sv
module kbd_link_responder
  import kbd_link_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NUM_LOCKS = 2,
  localparam int LOCK_ID_W = $clog2(NUM_LOCKS + 1),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [7:0]           cmd_data,
  input  logic                 key_valid,
  output logic                 key_ready,
  input  logic [KEY_W-1:0]     key_code,
  input  logic                 key_release,
  input  logic [LOCK_ID_W-1:0] key_lock,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [7:0]           rx_data
);
  logic             seq_clr, seq_push, led_mode;
  logic [7:0]       seq_data, head_data, push_data;
  logic             key_fire, key_drop, key_push, q_push;
  logic [CNT_W-1:0] q_level;

  kbd_cmd_seq seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .q_clr(seq_clr), .q_push(seq_push),
    .q_data(seq_data), .led_mode(led_mode)
  );

  assign key_ready = cmd_ready && !cmd_valid;
  assign key_fire  = key_valid && key_ready;

  kbd_lock_filter #(.NUM_LOCKS(NUM_LOCKS), .ID_W(LOCK_ID_W)) lock_i (
    .clk(clk), .rst_n(rst_n), .ev_fire(key_fire), .ev_lock(key_lock),
    .ev_release(key_release), .ev_drop(key_drop)
  );

  assign key_push  = key_fire && !key_drop;
  assign q_push    = seq_push || key_push;
  assign push_data = seq_push ? seq_data : {key_release, key_code};

  kbd_byte_queue #(.DEPTH(DEPTH)) q_i (
    .clk(clk), .rst_n(rst_n), .clr(seq_clr), .push(q_push),
    .push_data(push_data), .pop(rx_valid && rx_ready),
    .head_data(head_data), .level(q_level)
  );

  assign rx_valid = (q_level != '0);
  assign rx_data  = rx_valid ? head_data : 8'h00;
endmodule

// File: rtl/kbd_link_responder_chk.sv
module kbd_link_responder_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [7:0]       cmd_data,
  input logic             key_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [7:0]       rx_data,
  input logic [CNT_W-1:0] level,
  input logic             led_mode
);
  logic cmd_acc, rd;
  assign cmd_acc = cmd_valid && cmd_ready;
  assign rd      = rx_valid && rx_ready;

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH));

  assert_full_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CNT_W'(DEPTH) && !rd && !cmd_acc) |=> level == CNT_W'(DEPTH));

  assert_ident_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && !led_mode && cmd_data == 8'h01) |=> (rx_valid && rx_data == 8'hFF && !cmd_ready));

  assert_layout_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && !led_mode && (cmd_data == 8'h07 || cmd_data == 8'h0F)) |=> (rx_valid && rx_data == 8'hFE));

  assert_led_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && led_mode) |=> !led_mode);

  assert_cmd_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !key_ready);

  assert_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> rx_data == 8'h00);

  assert_next_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && level > CNT_W'(1) && !cmd_acc) |=> rx_valid);
endmodule

bind kbd_link_responder kbd_link_responder_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .key_ready(key_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .level(q_level), .led_mode(led_mode)
);

// File: tb/kbd_link_responder_tb_top.sv
module kbd_link_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_ready;
  logic [7:0] cmd_data = 8'h00;
  logic       key_valid = 1'b0, key_ready;
  logic [6:0] key_code = 7'h00;
  logic       key_release = 1'b0;
  logic [1:0] key_lock = 2'd0;
  logic       rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0;

  logic [7:0] mq [16];
  int         m_head = 0, m_cnt = 0;
  logic       m_led = 1'b0;
  logic [1:0] m_lock [2];

  always #10 clk = ~clk;

  kbd_link_responder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .key_release(key_release), .key_lock(key_lock),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_push(input logic [7:0] b);
    if (m_cnt < 16) begin
      mq[(m_head + m_cnt) % 16] = b;
      m_cnt++;
    end
  endfunction

  function automatic void m_clear();
    m_head = 0;
    m_cnt  = 0;
  endfunction

  function automatic int m_front();
    return (m_cnt > 0) ? int'(mq[m_head]) : 0;
  endfunction

  // Returns number of cycles cmd_ready must be low after acceptance.
  function automatic int m_cmd(input logic [7:0] b);
    if (m_led) begin
      m_led = 1'b0;
      return 0;
    end
    case (b)
      8'h01: begin m_clear(); m_push(8'hFF); m_push(8'h04); m_push(8'h7F); return 2; end
      8'h07, 8'h0F: begin m_clear(); m_push(8'hFE); m_push(8'h21); return 1; end
      8'h0E: begin m_led = 1'b1; return 0; end
      default: return 0;
    endcase
  endfunction

  function automatic void m_key(input logic [6:0] c, input logic rel, input logic [1:0] lk);
    logic drop;
    drop = 1'b0;
    if (lk != 2'd0) begin
      if (rel) begin
        m_lock[lk-1] = m_lock[lk-1] ^ 2'b10;
        drop = (m_lock[lk-1] == 2'd3);
      end else begin
        m_lock[lk-1] = m_lock[lk-1] ^ 2'b01;
        drop = (m_lock[lk-1] == 2'd2);
      end
    end
    if (!drop) m_push({rel, c});
  endfunction

  task automatic send_cmd(input logic [7:0] b, input string tag);
    int busy;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = b;
    #1;
    chk("R10 key_ready low while command offered", int'(key_ready), 0);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = m_cmd(b);
    for (int i = 0; i < busy; i++) begin
      #1;
      chk({tag, " R10 cmd_ready low during reply"}, int'(cmd_ready), 0);
      @(negedge clk);
    end
    #1;
    chk({tag, " R10 cmd_ready back high"}, int'(cmd_ready), 1);
  endtask

  task automatic send_key(input logic [6:0] c, input logic rel, input logic [1:0] lk);
    @(negedge clk);
    key_valid = 1'b1;
    key_code = c;
    key_release = rel;
    key_lock = lk;
    while (!key_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    key_valid = 1'b0;
    m_key(c, rel, lk);
  endtask

  task automatic read_one(input string tag);
    @(negedge clk);
    #1;
    chk({tag, " rx_valid"}, int'(rx_valid), (m_cnt > 0) ? 1 : 0);
    chk({tag, " rx_data"}, int'(rx_data), m_front());
    rx_ready = 1'b1;
    @(posedge clk);
    #1;
    rx_ready = 1'b0;
    if (m_cnt > 0) begin
      m_head = (m_head + 1) % 16;
      m_cnt--;
    end
  endtask

  // rx_ready held high: every next byte must appear on the very next cycle.
  task automatic drain(input string tag);
    @(negedge clk);
    rx_ready = 1'b1;
    while (m_cnt > 0) begin
      #1;
      chk({tag, " R11 rx_valid in burst"}, int'(rx_valid), 1);
      chk({tag, " rx_data in burst"}, int'(rx_data), m_front());
      m_head = (m_head + 1) % 16;
      m_cnt--;
      @(negedge clk);
    end
    #1;
    chk({tag, " R9 empty after drain"}, int'(rx_valid), 0);
    chk({tag, " R9 zero data when empty"}, int'(rx_data), 0);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_lock[0] = 2'd0;
    m_lock[1] = 2'd0;
    void'($urandom(32'h1234_5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 rx_valid after reset", int'(rx_valid), 0);
    chk("R1 rx_data after reset", int'(rx_data), 0);
    chk("R1 cmd_ready after reset", int'(cmd_ready), 1);
    chk("R1 key_ready after reset", int'(key_ready), 1);
    rst_n = 1'b1;

    read_one("R9 empty read");
    read_one("R9 empty read repeat");

    send_key(7'h1C, 1'b0, 2'd0);
    send_key(7'h1C, 1'b1, 2'd0);
    read_one("R6 press byte");
    read_one("R6 release byte");

    send_key(7'h05, 1'b0, 2'd0);
    send_key(7'h06, 1'b0, 2'd0);
    send_cmd(8'h01, "R2");
    drain("R2 ident reply");

    send_key(7'h11, 1'b0, 2'd0);
    send_cmd(8'h0F, "R3");
    drain("R3 layout reply 0F");
    send_cmd(8'h07, "R3");
    drain("R3 layout reply 07");

    send_key(7'h22, 1'b1, 2'd0);
    send_cmd(8'h0E, "R4");
    send_cmd(8'h01, "R4");
    read_one("R4 skipped byte left queue unchanged");
    read_one("R4 skipped byte added nothing");
    send_cmd(8'h01, "R4");
    drain("R4 after LED mode left");

    send_key(7'h33, 1'b0, 2'd0);
    send_cmd(8'h55, "R5");
    send_cmd(8'hA0, "R5");
    drain("R5 unknown commands ignored");

    send_key(7'h77, 1'b0, 2'd1);
    send_key(7'h12, 1'b0, 2'd2);
    send_key(7'h77, 1'b1, 2'd1);
    send_key(7'h77, 1'b0, 2'd1);
    send_key(7'h12, 1'b1, 2'd2);
    send_key(7'h77, 1'b1, 2'd1);
    send_key(7'h12, 1'b0, 2'd2);
    send_key(7'h12, 1'b1, 2'd2);
    drain("R7 lock filtering");

    for (int i = 0; i < 18; i++) send_key(7'(i + 8), 1'b0, 2'd0);
    drain("R8 overflow discard");
    for (int i = 0; i < 16; i++) send_key(7'(i), 1'b1, 2'd0);
    send_cmd(8'h07, "R8 clear of full queue");
    drain("R8 reply after full");

    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 12);
      if (r < 2) begin
        int s;
        logic [7:0] b;
        s = int'($urandom % 5);
        b = (s == 0) ? 8'h01 : (s == 1) ? 8'h0E : (s == 2) ? 8'h07 :
            (s == 3) ? 8'h0F : 8'($urandom);
        send_cmd(b, "R2 random command");
      end else if (r < 8) begin
        send_key(7'($urandom), 1'($urandom), 2'($urandom % 3));
      end else if (r < 11) begin
        read_one("R8 random read");
      end else begin
        drain("R11 random burst");
      end
    end
    drain("R11 final drain");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule